// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Pin Override

This block sends bytes as asynchronous serial frames on a single output line. Each frame has one low start bit, eight data bits sent least significant bit first, and one high stop bit. Every bit lasts sixteen pulses of a base-clock enable that runs at sixteen times the bit rate. Bytes arrive over a valid/ready write port. A busy flag stays high while a frame is on the line.

A transmit-enable control decides who drives the line. While it is high, the frame shifter drives the line and idles at mark. While it is low, the shifter is held in reset and the line follows two port bits. One is an output-enable bit; when it is set, the line shows a data bit written by software. When it is clear, the line is released and reads as high. Clearing transmit-enable stops a frame at once. Software therefore sends a break in two steps: it first clears the port data bit, then clears transmit-enable. The line then stays low for as long as software leaves both bits that way.

Top module: `uart_brk_tx`

## Requirements
- R1: While tx_en is 0 and pin_oe is 1, txd equals pin_dat in the same cycle, with no register on the path.
- R2: While tx_en is 0 and pin_oe is 0, txd is 1.
- R3: While tx_en is 1 and no frame is in progress, txd is 1 whatever pin_dat and pin_oe are.
- R4: A frame on txd is a start bit of 0, then wr_data bits 0 through 7 in that order, then a stop bit of 1.
- R5: Each bit of a frame lasts exactly 16 cycles in which tick16 is 1. Cycles with tick16 at 0 do not advance the frame.
- R6: wr_ready equals tx_en AND NOT busy. A byte is accepted on a rising clock edge at which wr_valid and wr_ready are both 1, and the start bit appears on txd in the cycle after that edge.
- R7: busy rises in the cycle after acceptance. It stays high until the edge that ends the sixteenth tick of the stop bit.
- R8: When tx_en goes to 0, busy drops and the frame is abandoned in that same cycle. The next accepted byte begins a fresh frame from its start bit.
- R9: wr_valid has no effect while tx_en is 0. After tx_en returns to 1, txd is 1 and busy is 0 until a byte is accepted.
- R10: wr_ready is 1 in the cycle after a stop bit ends, so a waiting byte starts its frame with no idle bit in between.
- R11: While rst_n is 0 and on leaving reset, busy is 0 and no frame is in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick16 | input | 1 | Base-clock enable at 16 times the bit rate |
| tx_en | input | 1 | Transmit enable; 0 holds the shifter in reset and hands the line to the port bits |
| pin_oe | input | 1 | Port output-enable bit used while tx_en is 0 |
| pin_dat | input | 1 | Port data bit shown on txd when pin_oe is 1 and tx_en is 0 |
| wr_valid | input | 1 | Byte write request |
| wr_data | input | 8 | Byte to send |
| wr_ready | output | 1 | Byte can be accepted this cycle |
| txd | output | 1 | Serial output line |
| busy | output | 1 | Frame in progress |

## Verification
The bench aims at the break sequence: it drops pin_dat and then tx_en partway through a frame. A design that finishes the frame, or that registers the override, would show a data bit or a late stop bit where a steady low is expected. Tick enables arrive at random, so an off-by-one bit length or a counter that counts plain clocks shows up as a bit boundary in the wrong cycle. Back-to-back bytes with wr_valid held high test the hand-off after the stop bit. A design that inserts an idle bit or loses the stop bit would put the next start bit in the wrong place. A byte offered while tx_en is low must never reach the line after re-enable.

// File: rtl/uart_brk_pkg.sv
// Shared definitions for the serial transmitter with pin override.
// Assumes nothing beyond a synchronous design style.
package uart_brk_pkg;

    // Transmitter activity state.
    typedef enum logic {
        TXS_IDLE = 1'b0,
        TXS_SEND = 1'b1
    } tx_state_e;

endpackage

// File: rtl/tx_bit_timer.sv
// Counts base-clock enables within one bit and flags the last one.
// Assumes TICKS_PER_BIT >= 2. Clearing or starting a frame restarts the count.
module tx_bit_timer #(
    parameter int TICKS_PER_BIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic running,
    input  logic tick,
    output logic bit_done
);
    localparam int CNT_W = $clog2(TICKS_PER_BIT);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TICKS_PER_BIT - 1);

    logic [CNT_W-1:0] cnt_q;

    // Flag the tick that closes the current bit.
    assign bit_done = running && tick && (cnt_q == CNT_LAST);

    // Advance the tick counter inside a bit, wrapping at the bit boundary.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || !running) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= bit_done ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/tx_frame_shift.sv
// Holds a framed byte and shifts it out one bit per bit period.
// Assumes load and advance are never high together.
module tx_frame_shift #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              load,
    input  logic [DATA_W-1:0] data,
    input  logic              advance,
    output logic              ser_bit,
    output logic              last_bit
);
    localparam int FRAME_W = DATA_W + 2;
    localparam int IDX_W   = $clog2(FRAME_W);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FRAME_W - 1);

    logic [FRAME_W-1:0] shreg_q;
    logic [IDX_W-1:0]   idx_q;

    assign ser_bit  = shreg_q[0];
    assign last_bit = (idx_q == IDX_LAST);

    // Load a new frame (stop, data, start) or shift toward the line.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            shreg_q <= '1;
            idx_q   <= '0;
        end else if (load) begin
            shreg_q <= {1'b1, data, 1'b0};
            idx_q   <= '0;
        end else if (advance) begin
            shreg_q <= {1'b1, shreg_q[FRAME_W-1:1]};
            idx_q   <= idx_q + 1'b1;
        end
    end
endmodule

// File: rtl/tx_pin_select.sv
// Chooses who drives the line: the shifter when enabled, else the port bits.
// Purely combinational so the override takes effect in the same cycle.
module tx_pin_select (
    input  logic tx_en,
    input  logic pin_oe,
    input  logic pin_dat,
    input  logic active,
    input  logic ser_bit,
    output logic txd
);
    // Line source selection; a released line reads as high.
    always_comb begin
        if (tx_en) begin
            txd = active ? ser_bit : 1'b1;
        end else if (pin_oe) begin
            txd = pin_dat;
        end else begin
            txd = 1'b1;
        end
    end
endmodule

// File: rtl/uart_brk_tx.sv
// Asynchronous serial transmitter with a software pin override.
// Sends start, DATA_W data bits LSB first and a stop bit, each lasting
// TICKS_PER_BIT base-clock enables. Clearing tx_en aborts at once.
module uart_brk_tx
    import uart_brk_pkg::*;
#(
    parameter int DATA_W        = 8,
    parameter int TICKS_PER_BIT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick16,
    input  logic              tx_en,
    input  logic              pin_oe,
    input  logic              pin_dat,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_ready,
    output logic              txd,
    output logic              busy
);
    tx_state_e state_q;
    logic      running;
    logic      accept;
    logic      bit_done;
    logic      ser_bit;
    logic      last_bit;

    assign running  = (state_q == TXS_SEND);
    assign wr_ready = tx_en && !running;
    assign accept   = wr_valid && wr_ready;
    assign busy     = tx_en && running;

    // Frame state: start on acceptance, stop after the last bit, abort on disable.
    always_ff @(posedge clk) begin
        if (!rst_n || !tx_en) begin
            state_q <= TXS_IDLE;
        end else if (accept) begin
            state_q <= TXS_SEND;
        end else if (bit_done && last_bit) begin
            state_q <= TXS_IDLE;
        end
    end

    tx_bit_timer #(.TICKS_PER_BIT(TICKS_PER_BIT)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (!tx_en || accept),
        .running  (running),
        .tick     (tick16),
        .bit_done (bit_done)
    );

    tx_frame_shift #(.DATA_W(DATA_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (!tx_en),
        .load     (accept),
        .data     (wr_data),
        .advance  (bit_done && !last_bit),
        .ser_bit  (ser_bit),
        .last_bit (last_bit)
    );

    tx_pin_select u_pin (
        .tx_en   (tx_en),
        .pin_oe  (pin_oe),
        .pin_dat (pin_dat),
        .active  (running),
        .ser_bit (ser_bit),
        .txd     (txd)
    );
endmodule

// File: rtl/uart_brk_tx_chk.sv
// Property checker for the serial transmitter, attached by bind.
module uart_brk_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic tick16,
    input logic tx_en,
    input logic pin_oe,
    input logic pin_dat,
    input logic wr_valid,
    input logic wr_ready,
    input logic txd,
    input logic busy
);
    assert_pin_follow_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_en && pin_oe) |-> (txd == pin_dat));

    assert_released_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_en && !pin_oe) |-> txd);

    assert_idle_mark_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && !busy) |-> txd);

    assert_start_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_ready) |=> (!tx_en || (!txd && busy)));

    assert_hold_no_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tick16) |=> (!tx_en || $stable(txd)));

    assert_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |-> !busy);

    assert_stop_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && tx_en) |-> $past(txd));
endmodule

bind uart_brk_tx uart_brk_tx_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick16   (tick16),
    .tx_en    (tx_en),
    .pin_oe   (pin_oe),
    .pin_dat  (pin_dat),
    .wr_valid (wr_valid),
    .wr_ready (wr_ready),
    .txd      (txd),
    .busy     (busy)
);

// File: tb/sim_uart_brk_tx.sv
module sim_uart_brk_tx;
    localparam int OVS = 16;
    localparam int FRAME_TICKS = 10 * OVS;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b0;
    logic       tx_en = 1'b0;
    logic       pin_oe = 1'b0;
    logic       pin_dat = 1'b0;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       wr_ready;
    logic       txd;
    logic       busy;

    int checks = 0;
    int failures = 0;
    bit finished = 0;
    bit model_on = 0;
    int tick_pct = 100;

    // Reference model state.
    bit       m_active = 0;
    int       m_ticks = 0;
    bit [9:0] m_frame = '1;

    always #10 clk = ~clk;

    uart_brk_tx u0 (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .tx_en(tx_en),
        .pin_oe(pin_oe), .pin_dat(pin_dat), .wr_valid(wr_valid),
        .wr_data(wr_data), .wr_ready(wr_ready), .txd(txd), .busy(busy)
    );

    function automatic bit exp_txd(bit en, bit oe, bit dat, bit act, int t, bit [9:0] f);
        if (!en) return oe ? dat : 1'b1;
        if (!act) return 1'b1;
        return f[t / OVS];
    endfunction

    task automatic check(bit act_v, bit exp_v, string req);
        checks++;
        if (act_v !== exp_v) begin
            failures++;
            $display("FAIL %s at %0t: actual=%0b expected=%0b", req, $time, act_v, exp_v);
        end
    endtask

    // Reference model updated at each edge from the sampled inputs.
    always @(posedge clk) begin
        if (!rst_n || !tx_en) begin
            m_active <= 0;
        end else if (!m_active && wr_valid) begin
            m_active <= 1;
            m_ticks  <= 0;
            m_frame  <= {1'b1, wr_data, 1'b0};
        end else if (m_active && tick16) begin
            if (m_ticks == FRAME_TICKS - 1) m_active <= 0;
            else m_ticks <= m_ticks + 1;
        end
    end

    // Compare outputs with the model away from the active edge.
    always @(negedge clk) begin
        if (model_on && rst_n) begin
            check(txd, exp_txd(tx_en, pin_oe, pin_dat, m_active, m_ticks, m_frame),
                  !tx_en ? (pin_oe ? "R1" : "R2") : (m_active ? "R4 R5" : "R3"));
            check(busy, tx_en && m_active, tx_en ? "R7" : "R8");
            check(wr_ready, tx_en && !m_active, "R6");
        end
    end

    task automatic step();
        @(posedge clk);
        #2;
        tick16 = ($urandom_range(99) < tick_pct);
    endtask

    initial begin
        #4_000_000;
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        // R11: reset state.
        repeat (3) begin
            step();
            @(negedge clk);
            check(busy, 1'b0, "R11");
        end
        pin_oe = 1'b1; pin_dat = 1'b1;
        @(negedge clk);
        check(txd, 1'b1, "R1");
        step();
        rst_n = 1'b1;
        model_on = 1;
        @(negedge clk);
        check(busy, 1'b0, "R11");
        // R1: port data shows immediately.
        pin_dat = 1'b0; #1;
        check(txd, 1'b0, "R1");
        pin_oe = 1'b0; #1;
        check(txd, 1'b1, "R2");
        // R9: valid while disabled is ignored.
        wr_valid = 1'b1; wr_data = 8'hA5;
        repeat (5) step();
        @(negedge clk);
        check(wr_ready, 1'b0, "R9");
        step();
        wr_valid = 1'b0;
        step();
        tx_en = 1'b1;
        repeat (3) step();
        @(negedge clk);
        check(txd, 1'b1, "R9");
        check(busy, 1'b0, "R9");
        // R10: back-to-back with valid held high.
        tick_pct = 100;
        wr_valid = 1'b1; wr_data = 8'h3C;
        step();
        wr_data = 8'hC3;
        while (busy !== 1'b1) step();
        while (busy === 1'b1) begin
            @(negedge clk);
            if (busy === 1'b0) break;
            step();
        end
        check(wr_ready, 1'b1, "R10");
        step();
        @(negedge clk);
        check(txd, 1'b0, "R10");
        check(busy, 1'b1, "R10");
        wr_valid = 1'b0;
        // Break in mid-frame: pin_dat low, then disable (R8, R1).
        pin_oe = 1'b1; pin_dat = 1'b1;
        repeat (40) step();
        pin_dat = 1'b0;
        step();
        tx_en = 1'b0; #1;
        check(txd, 1'b0, "R8");
        check(busy, 1'b0, "R8");
        repeat (50) begin
            step();
            @(negedge clk);
            check(txd, 1'b0, "R8");
        end
        pin_dat = 1'b1;
        step();
        tx_en = 1'b1;
        // Random traffic with random tick density and occasional aborts.
        for (int blk = 0; blk < 40; blk++) begin
            tick_pct = (blk % 3 == 0) ? 100 : $urandom_range(20, 90);
            for (int c = 0; c < 500; c++) begin
                step();
                wr_valid = ($urandom_range(3) != 0);
                wr_data  = 8'($urandom);
                pin_dat  = $urandom_range(1);
                pin_oe   = $urandom_range(1);
                if ($urandom_range(399) == 0) tx_en = ~tx_en;
                else if (!tx_en && $urandom_range(19) == 0) tx_en = 1'b1;
            end
        end
        step();
        @(negedge clk);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule